// File: doc/BRIEF.md
# Level-Based Interrupt Priority Controller

This block gathers interrupt requests from a configurable number of peripheral channels and decides which one, if any, the processor takes. A channel can compete only when its peripheral has raised its request flag and its enable flag is also set. Each channel carries its own 3-bit priority level and a service-mode bit. Among the competing channels, the numerically smallest level wins. When levels tie, the lowest channel index wins. The level value 7 is reserved to mean "never interrupt".

The winner is accepted only when three conditions hold together: its level is strictly below the processor's current level mask, the processor's global interrupt enable is set, and the processor signals an instruction boundary in that cycle. On acceptance the block registers the channel number, its level and its service-mode bit, and raises a valid flag. These outputs stay frozen until the processor acknowledges them. A peripheral withdraws its request simply by clearing its flag. Arbitration is a balanced tree of compare-select nodes that is evaluated every cycle.

Top module: `irq_level_arbiter`

## Requirements
- R1: A channel competes only when both its request flag and its enable bit are 1. If either is 0, that channel is never accepted.
- R2: Among competing channels, the one with the numerically smallest 3-bit level is accepted.
- R3: Among competing channels with equal level, the one with the lowest channel index is accepted.
- R4: A winner is accepted only if its level is strictly less than `cpu_mask`. A level equal to or above the mask is not accepted.
- R5: No acceptance happens while `cpu_int_en` is 0.
- R6: Acceptance happens only in a cycle where `insn_boundary` is 1. `take_valid` rises on the clock edge that ends that cycle.
- R7: `take_xfer` reports the accepted channel's mode bit: 0 means normal interrupt service, 1 means automatic transfer service.
- R8: A channel whose level is 7 never competes, even if it is the only one requesting.
- R9: While `take_valid` is 1 and `take_ack` is 0, `take_num`, `take_level` and `take_xfer` hold their values and no new acceptance happens. A cycle with `take_ack` at 1 clears `take_valid` at the next edge.
- R10: After synchronous reset, `take_valid`, `take_num`, `take_level` and `take_xfer` are all 0.
- R11: Once a peripheral clears its request flag, its channel drops out of arbitration, and the next-best competing channel is accepted instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_flag | input | NUM_CH | Per-channel peripheral request flags |
| req_en | input | NUM_CH | Per-channel request enables |
| ch_level | input | NUM_CH*3 | Per-channel level; channel i is at bits [3i+2:3i] |
| ch_xfer | input | NUM_CH | Per-channel service mode (1 = automatic transfer) |
| cpu_mask | input | 3 | Processor's current interrupt level mask |
| cpu_int_en | input | 1 | Global interrupt enable |
| insn_boundary | input | 1 | High in a cycle in which an instruction completes |
| take_ack | input | 1 | Processor acknowledges the held acceptance |
| take_valid | output | 1 | An accepted request is being presented |
| take_num | output | IDX_W | Binary index of the accepted channel |
| take_level | output | 3 | Level of the accepted channel |
| take_xfer | output | 1 | Service mode of the accepted channel |

## Verification
Every result is due exactly one clock edge after the cycle whose inputs produce it. Inputs applied in one cycle, including a boundary strobe, show up as a registered acceptance on the following edge. An acknowledge clears `take_valid` on the edge after it. The bench's driver applies each cycle's channel state just after a falling edge and queues the value the requirements predict for the next rising edge. The monitor pops and compares that value at the next falling edge, so each check lands exactly one register stage after its stimulus.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = lvl_t'(7);
endpackage

// File: rtl/irq_req_qualify.sv
module irq_req_qualify
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0]       flag,
  input  logic [NUM_CH-1:0]       en,
  input  logic [NUM_CH*LVL_W-1:0] lvl,
  output logic [NUM_CH-1:0]       active
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign active[c] = flag[c] & en[c] & (lvl[c*LVL_W +: LVL_W] != LVL_OFF);
  end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]       active,
  input  logic [NUM_CH*LVL_W-1:0] lvl,
  input  logic [NUM_CH-1:0]       mode,
  output logic                    win_valid,
  output lvl_t                    win_lvl,
  output logic [IDX_W-1:0]        win_idx,
  output logic                    win_mode
);
  localparam int PAD   = 1 << $clog2(NUM_CH);
  localparam int NODES = 2 * PAD - 1;

  logic             nv [NODES];
  lvl_t             nl [NODES];
  logic [IDX_W-1:0] ni [NODES];
  logic             nm [NODES];

  for (genvar g = 0; g < PAD; g++) begin : g_leaf
    if (g < NUM_CH) begin : g_real
      assign nv[PAD-1+g] = active[g];
      assign nl[PAD-1+g] = lvl[g*LVL_W +: LVL_W];
      assign ni[PAD-1+g] = IDX_W'(g);
      assign nm[PAD-1+g] = mode[g];
    end else begin : g_pad
      assign nv[PAD-1+g] = 1'b0;
      assign nl[PAD-1+g] = LVL_OFF;
      assign ni[PAD-1+g] = '0;
      assign nm[PAD-1+g] = 1'b0;
    end
  end

  for (genvar n = 0; n < PAD - 1; n++) begin : g_node
    localparam int LC = 2 * n + 1;
    localparam int RC = 2 * n + 2;
    logic take_left;
    // left subtree holds lower indices, so ties resolve to it
    assign take_left = nv[LC] && (!nv[RC] || (nl[LC] <= nl[RC]));
    assign nv[n] = nv[LC] | nv[RC];
    assign nl[n] = take_left ? nl[LC] : nl[RC];
    assign ni[n] = take_left ? ni[LC] : ni[RC];
    assign nm[n] = take_left ? nm[LC] : nm[RC];
  end

  assign win_valid = nv[0];
  assign win_lvl   = nl[0];
  assign win_idx   = ni[0];
  assign win_mode  = nm[0];
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_arb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_valid,
  input  lvl_t             win_lvl,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             win_mode,
  input  lvl_t             mask,
  input  logic             int_en,
  input  logic             boundary,
  input  logic             ack,
  output logic             held_valid,
  output logic [IDX_W-1:0] held_idx,
  output lvl_t             held_lvl,
  output logic             held_mode
);
  logic fire;
  assign fire = !held_valid && boundary && int_en && win_valid && (win_lvl < mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
      held_idx   <= '0;
      held_lvl   <= '0;
      held_mode  <= 1'b0;
    end else if (fire) begin
      held_valid <= 1'b1;
      held_idx   <= win_idx;
      held_lvl   <= win_lvl;
      held_mode  <= win_mode;
    end else if (held_valid && ack) begin
      held_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       req_flag,
  input  logic [NUM_CH-1:0]       req_en,
  input  logic [NUM_CH*LVL_W-1:0] ch_level,
  input  logic [NUM_CH-1:0]       ch_xfer,
  input  logic [LVL_W-1:0]        cpu_mask,
  input  logic                    cpu_int_en,
  input  logic                    insn_boundary,
  input  logic                    take_ack,
  output logic                    take_valid,
  output logic [IDX_W-1:0]        take_num,
  output logic [LVL_W-1:0]        take_level,
  output logic                    take_xfer
);
  logic [NUM_CH-1:0] active;
  logic              w_valid;
  lvl_t              w_lvl;
  logic [IDX_W-1:0]  w_idx;
  logic              w_mode;

  irq_req_qualify #(.NUM_CH(NUM_CH)) u_qual (
    .flag(req_flag), .en(req_en), .lvl(ch_level), .active(active)
  );

  irq_prio_tree #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_tree (
    .active(active), .lvl(ch_level), .mode(ch_xfer),
    .win_valid(w_valid), .win_lvl(w_lvl), .win_idx(w_idx), .win_mode(w_mode)
  );

  irq_accept_gate #(.IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst(rst),
    .win_valid(w_valid), .win_lvl(w_lvl), .win_idx(w_idx), .win_mode(w_mode),
    .mask(cpu_mask), .int_en(cpu_int_en), .boundary(insn_boundary), .ack(take_ack),
    .held_valid(take_valid), .held_idx(take_num), .held_lvl(take_level),
    .held_mode(take_xfer)
  );
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_CH-1:0]   req_flag,
  input logic [NUM_CH-1:0]   req_en,
  input logic [2:0]          cpu_mask,
  input logic                cpu_int_en,
  input logic                insn_boundary,
  input logic                take_ack,
  input logic                take_valid,
  input logic [IDX_W-1:0]    take_num,
  input logic [2:0]          take_level,
  input logic                take_xfer
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    take_valid && !take_ack |=> take_valid && $stable(take_num)
      && $stable(take_level) && $stable(take_xfer));

  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    take_valid && take_ack |=> !take_valid);

  assert_boundary_only_R6: assert property (@(posedge clk) disable iff (rst)
    !take_valid && !insn_boundary |=> !take_valid);

  assert_int_en_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !take_valid && !cpu_int_en |=> !take_valid);

  assert_below_mask_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(take_valid) |-> take_level < $past(cpu_mask));

  assert_no_level7_R8: assert property (@(posedge clk) disable iff (rst)
    take_valid |-> take_level != 3'd7);

  assert_req_present_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(take_valid) |->
      ((($past(req_flag & req_en)) >> take_num) & NUM_CH'(1)) != '0);
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req_flag(req_flag), .req_en(req_en),
  .cpu_mask(cpu_mask), .cpu_int_en(cpu_int_en), .insn_boundary(insn_boundary),
  .take_ack(take_ack), .take_valid(take_valid), .take_num(take_num),
  .take_level(take_level), .take_xfer(take_xfer)
);

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_flag = '0, req_en = '0, ch_xfer = '0;
  logic [N*3-1:0] ch_level = '0;
  logic [2:0]    cpu_mask = 3'd7;
  logic          cpu_int_en = 1'b1, insn_boundary = 1'b0, take_ack = 1'b0;
  logic          take_valid, take_xfer;
  logic [IW-1:0] take_num;
  logic [2:0]    take_level;

  irq_level_arbiter #(.NUM_CH(N)) u_irq_level_arbiter (
    .clk(clk), .rst(rst), .req_flag(req_flag), .req_en(req_en),
    .ch_level(ch_level), .ch_xfer(ch_xfer), .cpu_mask(cpu_mask),
    .cpu_int_en(cpu_int_en), .insn_boundary(insn_boundary), .take_ack(take_ack),
    .take_valid(take_valid), .take_num(take_num), .take_level(take_level),
    .take_xfer(take_xfer)
  );

  always #4 clk = ~clk;

  // staged per-channel state, applied by step()
  bit       s_flag [N];
  bit       s_en   [N];
  bit [2:0] s_lvl  [N];
  bit       s_mode [N];
  bit [2:0] s_mask = 3'd7;
  bit       s_ie   = 1'b1;

  typedef struct {
    bit    v;
    int    num;
    int    lvl;
    bit    mode;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  bit m_v = 0; int m_num = 0; int m_lvl = 0; bit m_mode = 0;
  int checks = 0, failures = 0;

  task automatic set_ch(int c, bit f, bit e, int l, bit m);
    s_flag[c] = f; s_en[c] = e; s_lvl[c] = 3'(l); s_mode[c] = m;
  endtask

  task automatic clear_all();
    for (int c = 0; c < N; c++) set_ch(c, 0, 0, 0, 0);
  endtask

  task automatic step(string tag, bit bnd, bit ack);
    int best;
    exp_t e;
    @(negedge clk); #1;
    for (int c = 0; c < N; c++) begin
      req_flag[c] = s_flag[c]; req_en[c] = s_en[c];
      ch_level[c*3 +: 3] = s_lvl[c]; ch_xfer[c] = s_mode[c];
    end
    cpu_mask = s_mask; cpu_int_en = s_ie;
    insn_boundary = bnd; take_ack = ack;
    best = -1;
    for (int c = 0; c < N; c++)
      if (s_flag[c] && s_en[c] && s_lvl[c] != 3'd7)
        if (best < 0 || s_lvl[c] < s_lvl[best]) best = c;
    if (m_v) begin
      if (ack) m_v = 0;
    end else if (bnd && s_ie && best >= 0 && s_lvl[best] < s_mask) begin
      m_v = 1; m_num = best; m_lvl = s_lvl[best]; m_mode = s_mode[best];
    end
    e.v = m_v; e.num = m_num; e.lvl = m_lvl; e.mode = m_mode; e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (take_valid !== e.v ||
          (e.v && (int'(take_num) != e.num || int'(take_level) != e.lvl ||
                   take_xfer !== e.mode))) begin
        failures++;
        $display("FAIL %s: got v=%0b num=%0d lvl=%0d mode=%0b, expected v=%0b num=%0d lvl=%0d mode=%0b",
                 e.tag, take_valid, take_num, take_level, take_xfer,
                 e.v, e.num, e.lvl, e.mode);
      end
    end
  end

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++; // R10 reset state
    if (take_valid !== 0 || take_num !== '0 || take_level !== 0 || take_xfer !== 0) begin
      failures++;
      $display("FAIL R10: got v=%0b num=%0d lvl=%0d mode=%0b, expected all 0",
               take_valid, take_num, take_level, take_xfer);
    end

    // R1: flag without enable, enable without flag, then both
    set_ch(3, 1, 0, 2, 0); step("R1 flag only", 1, 0);
    set_ch(3, 0, 1, 2, 0); step("R1 enable only", 1, 0);
    set_ch(3, 1, 1, 2, 0); step("R1 both set", 1, 0);
    step("R9 ack", 0, 1);

    // R2: lower level wins over lower index
    clear_all(); set_ch(2, 1, 1, 5, 0); set_ch(9, 1, 1, 1, 0);
    step("R2 lowest level", 1, 0); step("R9 ack", 0, 1);

    // R3: tie at level 2 goes to channel 4
    clear_all(); set_ch(12, 1, 1, 3, 0); set_ch(6, 1, 1, 2, 0); set_ch(4, 1, 1, 2, 0);
    step("R3 tie lowest index", 1, 0); step("R9 ack", 0, 1);

    // R4: strict compare against mask
    clear_all(); set_ch(7, 1, 1, 2, 0); s_mask = 3'd2;
    step("R4 level equals mask", 1, 0);
    s_mask = 3'd1; step("R4 level above mask", 1, 0);
    s_mask = 3'd3; step("R4 level below mask", 1, 0); step("R9 ack", 0, 1);
    s_mask = 3'd7;

    // R5: global enable off
    s_ie = 0; step("R5 int disabled", 1, 0); step("R5 int disabled", 1, 0);
    s_ie = 1;

    // R6: no boundary, then boundary
    step("R6 no boundary", 0, 0); step("R6 no boundary", 0, 0);
    step("R6 boundary", 1, 0); step("R9 ack", 0, 1);

    // R7: mode reported for both values
    clear_all(); set_ch(15, 1, 1, 0, 1);
    step("R7 xfer mode 1", 1, 0); step("R9 ack", 0, 1);
    set_ch(15, 1, 1, 0, 0);
    step("R7 xfer mode 0", 1, 0); step("R9 ack", 0, 1);

    // R8: level 7 never competes
    clear_all(); set_ch(0, 1, 1, 7, 1);
    step("R8 lone level 7", 1, 0);
    set_ch(10, 1, 1, 6, 0);
    step("R8 level 7 skipped", 1, 0); step("R9 ack", 0, 1);

    // R9: hold against a better request until acknowledged
    clear_all(); set_ch(5, 1, 1, 4, 1);
    step("R9 accept ch5", 1, 0);
    set_ch(0, 1, 1, 0, 0);
    step("R9 hold", 1, 0); step("R9 hold", 1, 0); step("R9 hold", 0, 0);
    step("R9 ack clears", 1, 1);
    step("R9 next accept", 1, 0); step("R9 ack", 0, 1);

    // R11: withdrawal by flag clear
    clear_all(); set_ch(1, 1, 1, 1, 0); set_ch(8, 1, 1, 3, 1);
    step("R11 ch1 first", 1, 0); step("R9 ack", 0, 1);
    set_ch(1, 0, 1, 1, 0);
    step("R11 ch8 after clear", 1, 0); step("R9 ack", 0, 1);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule